// File: doc/BRIEF.md
# DMA Bus-Release Mode Sequencer

This block runs one DMA channel. It moves a block of bytes between a peripheral and memory, one byte per transfer cycle. A processor programs it with a start address, a byte count, a direction and a bus-release policy, then arms it with a single write strobe. The sequencer waits for the peripheral to signal ready, requests the system bus, and drives addresses and read or write strobes while it owns the bus. Each byte steps the address up by one and the remaining count down by one.

The policy decides when the bus goes back to the processor. In single mode the bus is released after every byte, so processor and DMA cycles interleave. In demand mode the bus is kept for as long as the peripheral stays ready. In block mode the bus is kept until the whole block is done, and the sequencer stalls on the bus while ready is low. Every policy stops at end of block. At that point the sequencer pulses done and idles until it is armed again.

The processor side is assumed to drop its acknowledge no later than one cycle after the request falls.

Top module: `dma_mode_seq`

## Requirements
- R1: A synchronous reset (`rst` high) forces `bus_req`, `rd_stb`, `wr_stb` and `done` low, clears the address to 0 and leaves the sequencer idle and not armed.
- R2: `cfg_we` is accepted only while idle. It captures `cfg_addr`, `cfg_len`, `cfg_mode` and `cfg_dir`. A `cfg_we` seen while a block is in progress has no effect on the block.
- R3: While armed, `bus_req` rises only in the cycle after `dev_rdy` was sampled high. While `dev_rdy` stays low, no request is made.
- R4: `bus_req` stays high until `bus_ack` is sampled high. No strobe is driven before that. The first strobe comes in the cycle after the acknowledge is sampled.
- R5: Each byte is one clock with exactly one strobe high and `xfer_addr` holding the current address. The strobe is `rd_stb` when `cfg_dir`=0 and `wr_stb` when `cfg_dir`=1. After each byte the address goes up by 1 and the remaining count goes down by 1, so a block of N bytes gives exactly N strobes.
- R6: Mode 2'b00 (single) moves one byte per bus tenure. `bus_req` is low in the cycle after each strobe, and a new request needs `dev_rdy` sampled high again.
- R7: Mode 2'b01 (demand) strobes on back-to-back cycles while `dev_rdy` is sampled high in each strobe cycle. If `dev_rdy` is low in a strobe cycle, the bus is released in the next cycle.
- R8: Mode 2'b10 (block) keeps `bus_req` high from the first strobe to the last one. If `dev_rdy` is low in a strobe cycle, the following cycles hold the bus with no strobe until `dev_rdy` is sampled high. The next cycle then strobes, so the whole block is one tenure.
- R9: Mode 2'b11 behaves as single mode with the default parameters.
- R10: In the cycle after the strobe that brings the count to zero, `bus_req` is low and `done` is high for exactly one clock. After that, no request is made, whatever `dev_rdy` does, until the block is armed again.
- R11: Arming with a length of 0 raises `done` in the next cycle and never raises `bus_req`.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| cfg_we | input | 1 | Arm strobe that loads the configuration fields |
| cfg_mode | input | 2 | Release policy: 00 single, 01 demand, 10 block, 11 reserved |
| cfg_dir | input | 1 | 0 = read strobes, 1 = write strobes |
| cfg_addr | input | ADDR_W | Start address |
| cfg_len | input | CNT_W | Byte count |
| dev_rdy | input | 1 | Peripheral ready |
| bus_ack | input | 1 | Bus grant from the processor |
| bus_req | output | 1 | Bus request to the processor |
| xfer_addr | output | ADDR_W | Current transfer address |
| rd_stb | output | 1 | Read strobe, one clock per byte |
| wr_stb | output | 1 | Write strobe, one clock per byte |
| done | output | 1 | One-clock end-of-block pulse |

## Verification
The bench goes after a ready line that drops in the very cycle a byte is strobed. A demand-mode design that sampled ready at the wrong point would release one byte early or late. A block-mode design would release the bus instead of stalling on it, and the tenure count would exceed one. It also checks that a stale acknowledge from the previous tenure is not taken as a grant in single mode. It checks that an arm write during a transfer does not restart or lengthen the block. It checks that a zero-length block ends without touching the bus. A per-cycle reference comparison catches an off-by-one in the final count as a missing or extra strobe and a misplaced done pulse.

// File: rtl/dma_seq_pkg.sv
package dma_seq_pkg;

   typedef enum logic [1:0] {
      MODE_SINGLE = 2'b00,
      MODE_DEMAND = 2'b01,
      MODE_BLOCK  = 2'b10,
      MODE_RSVD   = 2'b11
   } xfer_mode_e;

   typedef enum logic [2:0] {
      ST_IDLE,
      ST_WAIT,
      ST_REQ,
      ST_MOVE,
      ST_HOLD
   } seq_state_e;

endpackage

// File: rtl/dma_pos_track.sv
module dma_pos_track #(
   parameter int ADDR_W = 16,
   parameter int CNT_W  = 16
) (
   input  logic              clk,
   input  logic              rst,
   input  logic              load,
   input  logic              step,
   input  logic [ADDR_W-1:0] ld_addr,
   input  logic [CNT_W-1:0]  ld_len,
   output logic [ADDR_W-1:0] addr,
   output logic              last
);

   localparam logic [CNT_W-1:0]  CNT_ONE  = CNT_W'(1);
   localparam logic [ADDR_W-1:0] ADDR_ONE = ADDR_W'(1);

   logic [CNT_W-1:0] left_q;

   always_ff @(posedge clk) begin
      if (rst) begin
         addr   <= '0;
         left_q <= '0;
      end else if (load) begin
         addr   <= ld_addr;
         left_q <= ld_len;
      end else if (step) begin
         addr   <= addr + ADDR_ONE;
         left_q <= left_q - CNT_ONE;
      end
   end

   assign last = (left_q == CNT_ONE);

   // R5
   count_step_chk: assert property (@(posedge clk) disable iff (rst)
      (step && !load) |=> (left_q == $past(left_q) - CNT_ONE));

   // R5
   addr_step_chk: assert property (@(posedge clk) disable iff (rst)
      (step && !load) |=> (addr == $past(addr) + ADDR_ONE));

endmodule

// File: rtl/dma_seq_fsm.sv
module dma_seq_fsm
   import dma_seq_pkg::*;
#(
   parameter bit RSVD_AS_BLOCK = 1'b0
) (
   input  logic       clk,
   input  logic       rst,
   input  logic       arm,
   input  logic [1:0] mode_in,
   input  logic       len_zero,
   input  logic       dev_rdy,
   input  logic       bus_ack,
   input  logic       last,
   output logic       load,
   output logic       step,
   output logic       bus_req,
   output logic       done
);

   seq_state_e state_q, state_d;
   xfer_mode_e mode_q, mode_pick;
   logic       done_d;

   generate
      if (RSVD_AS_BLOCK) begin : g_rsvd_block
         assign mode_pick = (xfer_mode_e'(mode_in) == MODE_RSVD) ? MODE_BLOCK
                                                                  : xfer_mode_e'(mode_in);
      end else begin : g_rsvd_single
         assign mode_pick = (xfer_mode_e'(mode_in) == MODE_RSVD) ? MODE_SINGLE
                                                                  : xfer_mode_e'(mode_in);
      end
   endgenerate

   assign load    = arm && (state_q == ST_IDLE);
   assign step    = (state_q == ST_MOVE);
   assign bus_req = (state_q == ST_REQ) || (state_q == ST_MOVE) || (state_q == ST_HOLD);

   always_comb begin
      state_d = state_q;
      done_d  = 1'b0;
      unique case (state_q)
         ST_IDLE: if (arm) begin
            if (len_zero) done_d = 1'b1;
            else          state_d = ST_WAIT;
         end
         ST_WAIT: if (dev_rdy) state_d = ST_REQ;
         ST_REQ:  if (bus_ack) state_d = ST_MOVE;
         ST_MOVE: begin
            if (last) begin
               state_d = ST_IDLE;
               done_d  = 1'b1;
            end else begin
               unique case (mode_q)
                  MODE_DEMAND: state_d = dev_rdy ? ST_MOVE : ST_WAIT;
                  MODE_BLOCK:  state_d = dev_rdy ? ST_MOVE : ST_HOLD;
                  default:     state_d = ST_WAIT;
               endcase
            end
         end
         ST_HOLD: if (dev_rdy) state_d = ST_MOVE;
         default: state_d = ST_IDLE;
      endcase
   end

   always_ff @(posedge clk) begin
      if (rst) begin
         state_q <= ST_IDLE;
         mode_q  <= MODE_SINGLE;
         done    <= 1'b0;
      end else begin
         state_q <= state_d;
         done    <= done_d;
         if (load) mode_q <= mode_pick;
      end
   end

   // R3
   req_needs_rdy_chk: assert property (@(posedge clk) disable iff (rst)
      $rose(bus_req) |-> $past(dev_rdy));

   // R4
   move_after_ack_chk: assert property (@(posedge clk) disable iff (rst)
      $rose(step) |-> $past(bus_ack));

   // R6
   single_release_chk: assert property (@(posedge clk) disable iff (rst)
      (step && mode_q == MODE_SINGLE) |=> !bus_req);

   // R8
   block_hold_chk: assert property (@(posedge clk) disable iff (rst)
      (step && mode_q == MODE_BLOCK && !last) |=> bus_req);

   // R10
   done_pulse_chk: assert property (@(posedge clk) disable iff (rst)
      done |=> !done);

   // R10
   done_released_chk: assert property (@(posedge clk) disable iff (rst)
      done |-> !bus_req);

endmodule

// File: rtl/dma_mode_seq.sv
module dma_mode_seq #(
   parameter int ADDR_W        = 16,
   parameter int CNT_W         = 16,
   parameter bit RSVD_AS_BLOCK = 1'b0
) (
   input  logic              clk,
   input  logic              rst,
   input  logic              cfg_we,
   input  logic [1:0]        cfg_mode,
   input  logic              cfg_dir,
   input  logic [ADDR_W-1:0] cfg_addr,
   input  logic [CNT_W-1:0]  cfg_len,
   input  logic              dev_rdy,
   input  logic              bus_ack,
   output logic              bus_req,
   output logic [ADDR_W-1:0] xfer_addr,
   output logic              rd_stb,
   output logic              wr_stb,
   output logic              done
);

   generate
      if (ADDR_W < 2) begin : g_bad_addr_w
         $error("dma_mode_seq: ADDR_W must be at least 2");
      end
      if (CNT_W < 1) begin : g_bad_cnt_w
         $error("dma_mode_seq: CNT_W must be at least 1");
      end
   endgenerate

   logic load, step, last, dir_q;

   always_ff @(posedge clk) begin
      if (rst)       dir_q <= 1'b0;
      else if (load) dir_q <= cfg_dir;
   end

   dma_pos_track #(
      .ADDR_W (ADDR_W),
      .CNT_W  (CNT_W)
   ) u_track (
      .clk     (clk),
      .rst     (rst),
      .load    (load),
      .step    (step),
      .ld_addr (cfg_addr),
      .ld_len  (cfg_len),
      .addr    (xfer_addr),
      .last    (last)
   );

   dma_seq_fsm #(
      .RSVD_AS_BLOCK (RSVD_AS_BLOCK)
   ) u_fsm (
      .clk      (clk),
      .rst      (rst),
      .arm      (cfg_we),
      .mode_in  (cfg_mode),
      .len_zero (cfg_len == '0),
      .dev_rdy  (dev_rdy),
      .bus_ack  (bus_ack),
      .last     (last),
      .load     (load),
      .step     (step),
      .bus_req  (bus_req),
      .done     (done)
   );

   assign rd_stb = step && !dir_q;
   assign wr_stb = step &&  dir_q;

   // R5
   stb_excl_chk: assert property (@(posedge clk) disable iff (rst)
      $onehot0({rd_stb, wr_stb}));

   // R4
   stb_on_bus_chk: assert property (@(posedge clk) disable iff (rst)
      (rd_stb || wr_stb) |-> bus_req);

endmodule

// File: tb/dma_mode_seq_test.sv
`timescale 1ns/1ps
module dma_mode_seq_test;

   logic        clk = 1'b0;
   logic        rst = 1'b1;
   logic        cfg_we = 1'b0;
   logic [1:0]  cfg_mode = 2'b00;
   logic        cfg_dir = 1'b0;
   logic [15:0] cfg_addr = '0;
   logic [15:0] cfg_len = '0;
   logic        dev_rdy = 1'b0;
   logic        bus_ack;
   logic        bus_req, rd_stb, wr_stb, done;
   logic [15:0] xfer_addr;

   always #2.5 clk = ~clk;

   dma_mode_seq uut (
      .clk (clk), .rst (rst), .cfg_we (cfg_we), .cfg_mode (cfg_mode),
      .cfg_dir (cfg_dir), .cfg_addr (cfg_addr), .cfg_len (cfg_len),
      .dev_rdy (dev_rdy), .bus_ack (bus_ack), .bus_req (bus_req),
      .xfer_addr (xfer_addr), .rd_stb (rd_stb), .wr_stb (wr_stb), .done (done)
   );

   // processor: grants two cycles after a request, drops one cycle after release
   logic [1:0] ackp;
   always @(posedge clk) begin
      if (rst) ackp <= '0;
      else     ackp <= {ackp[0], bus_req};
   end
   assign bus_ack = ackp[0] & ackp[1];

   int total = 0;
   int bad   = 0;

   task automatic chk(input bit ok, input string tag, input int act, input int exp);
      total++;
      if (!ok) begin
         bad++;
         $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
      end
   endtask

   // behavioural reference: phase 0 idle,1 waiting for ready,2 requesting,3 moving,4 holding
   int   m_phase = 0;
   int   m_mode  = 0;
   int   m_left  = 0;
   int   m_addr  = 0;
   bit   m_dir   = 0;
   bit   m_done  = 0;

   always @(posedge clk) begin
      if (rst) begin
         m_phase <= 0; m_done <= 0; m_addr <= 0; m_left <= 0; m_dir <= 0; m_mode <= 0;
      end else begin
         m_done <= 0;
         case (m_phase)
            0: if (cfg_we) begin
               m_addr <= cfg_addr; m_left <= cfg_len; m_dir <= cfg_dir;
               m_mode <= (cfg_mode == 3) ? 0 : cfg_mode;
               if (cfg_len == 0) m_done <= 1; else m_phase <= 1;
            end
            1: if (dev_rdy) m_phase <= 2;
            2: if (bus_ack) m_phase <= 3;
            3: begin
               m_addr <= (m_addr + 1) % 65536;
               m_left <= m_left - 1;
               if (m_left == 1) begin m_phase <= 0; m_done <= 1; end
               else if (m_mode == 0) m_phase <= 1;
               else if (dev_rdy) m_phase <= 3;
               else m_phase <= (m_mode == 1) ? 1 : 4;
            end
            4: if (dev_rdy) m_phase <= 3;
            default: m_phase <= 0;
         endcase
      end
   end

   // per-cycle comparison against the reference
   always @(negedge clk) begin
      if (!rst) begin
         chk(bus_req == (m_phase >= 2), "R4 bus_req", bus_req, m_phase >= 2);
         chk(rd_stb == (m_phase == 3 && !m_dir), "R5 rd_stb", rd_stb, m_phase == 3 && !m_dir);
         chk(wr_stb == (m_phase == 3 && m_dir), "R5 wr_stb", wr_stb, m_phase == 3 && m_dir);
         chk(int'(xfer_addr) == m_addr, "R5 xfer_addr", xfer_addr, m_addr);
         chk(done == m_done, "R10 done", done, m_done);
      end
   end

   int nstb = 0;
   int nten = 0;
   logic req_d = 1'b0;
   always @(posedge clk) begin
      if (!rst) begin
         if (rd_stb || wr_stb) nstb++;
         if (bus_req && !req_d) nten++;
         req_d <= bus_req;
      end
   end

   task automatic arm(input logic [1:0] m, input logic [15:0] a, input logic [15:0] n, input logic d);
      cfg_mode = m; cfg_addr = a; cfg_len = n; cfg_dir = d; cfg_we = 1'b1;
      @(negedge clk);
      cfg_we = 1'b0;
   endtask

   task automatic wait_done(input string tag);
      for (int k = 0; k < 400 && !done; k++) @(negedge clk);
      chk(done, tag, done, 1);
      @(negedge clk);
   endtask

   task automatic clr;
      nstb = 0; nten = 0;
   endtask

   initial begin
      #(200000 * 5);
      bad++; total++;
      $display("FAIL watchdog actual=0 expected=1");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
   end

   initial begin
      repeat (4) @(negedge clk);
      // R1: reset state
      chk(!bus_req && !rd_stb && !wr_stb && !done, "R1 outputs low", bus_req, 0);
      chk(xfer_addr == 16'h0, "R1 address cleared", xfer_addr, 0);
      rst = 1'b0;
      @(negedge clk);

      // R3: armed but peripheral not ready
      clr();
      arm(2'b00, 16'h0100, 16'd3, 1'b0);
      repeat (10) @(negedge clk);
      chk(nten == 0, "R3 no request without ready", nten, 0);
      // R6: single mode, one byte per tenure
      dev_rdy = 1'b1;
      wait_done("R6 single done");
      chk(nstb == 3, "R5 single strobe count", nstb, 3);
      chk(nten == 3, "R6 tenures in single mode", nten, 3);
      chk(xfer_addr == 16'h0103, "R5 final address", xfer_addr, 16'h0103);

      // R10: nothing after done while ready stays high
      clr();
      repeat (10) @(negedge clk);
      chk(nten == 0, "R10 idle after done", nten, 0);

      // R7: demand mode, steady ready
      clr();
      arm(2'b01, 16'h2000, 16'd6, 1'b1);
      wait_done("R7 demand done");
      chk(nstb == 6, "R7 demand strobes", nstb, 6);
      chk(nten == 1, "R7 single tenure with steady ready", nten, 1);

      // R7: demand mode, ready drops mid-block
      clr();
      dev_rdy = 1'b1;
      arm(2'b01, 16'hFFFE, 16'd8, 1'b0);
      repeat (5) @(negedge clk);
      dev_rdy = 1'b0;
      repeat (6) @(negedge clk);
      dev_rdy = 1'b1;
      wait_done("R7 demand done after pause");
      chk(nstb == 8, "R7 demand strobes after pause", nstb, 8);
      chk(nten >= 2, "R7 bus released on ready drop", nten, 2);
      chk(xfer_addr == 16'h0006, "R5 address wraps", xfer_addr, 16'h0006);

      // R8: block mode holds the bus across a ready gap
      clr();
      arm(2'b10, 16'h4000, 16'd6, 1'b1);
      repeat (5) @(negedge clk);
      dev_rdy = 1'b0;
      repeat (6) @(negedge clk);
      dev_rdy = 1'b1;
      wait_done("R8 block done");
      chk(nstb == 6, "R8 block strobes", nstb, 6);
      chk(nten == 1, "R8 one tenure for whole block", nten, 1);

      // R9: reserved mode acts as single
      clr();
      arm(2'b11, 16'h0500, 16'd4, 1'b0);
      wait_done("R9 reserved done");
      chk(nten == 4, "R9 reserved tenures", nten, 4);

      // R11: zero length
      clr();
      arm(2'b10, 16'h0600, 16'd0, 1'b0);
      chk(done, "R11 done next cycle", done, 1);
      @(negedge clk);
      repeat (5) @(negedge clk);
      chk(nten == 0, "R11 no request", nten, 0);

      // R2: arm write during a block is ignored
      clr();
      arm(2'b10, 16'h7000, 16'd4, 1'b0);
      repeat (2) @(negedge clk);
      arm(2'b00, 16'h9000, 16'd9, 1'b1);
      wait_done("R2 block done");
      chk(nstb == 4, "R2 busy arm ignored count", nstb, 4);
      chk(xfer_addr == 16'h7004, "R2 busy arm ignored address", xfer_addr, 16'h7004);

      repeat (4) @(negedge clk);
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
   end

endmodule